// File: doc/BRIEF.md
# Clocked Programmable Delay and One-Shot

This block is a timing element that works in a sampled domain set by a fast reference clock. A one-bit input is sampled on every clock edge. An 8-bit code sets how many ticks later each input transition shows up on the main output. A delay can be longer than the input's high or low time, so a queue keeps several transitions in flight at once. A second output follows the input at a fixed latency. At code zero this output trails the main output by exactly one tick, so it can serve as a timing reference for small relative delays.

A mode input turns the block into a one-shot. A rising input edge starts a pulse on the second output, which then acts as a PWM output. The pulse rises at the reference latency and stays high for as many ticks as the code says. Trigger edges that arrive during a pulse are ignored. In this mode the main output carries the delayed input inverted. Feeding the main output back to the input therefore makes a free-running oscillator, and the code sets its period.

Top module: `tick_delay_oneshot`

## Requirements
- R1: A synchronous active-high reset drives all three outputs low and empties the transition queue. Transitions queued before the reset never reach the main output.
- R2: Mode input low (delay mode): an input transition sampled at clock edge k appears on `out_main` right after edge k + (REF_LAT - 1) + code. With the default REF_LAT of 3, this is k + 2 + code.
- R3: Transitions keep their own timing and their order when several are in flight at once. This includes delays longer than the input pulse width and a one-tick pulse. The queue can also accept a new transition in the same cycle that it releases an old one.
- R4: In delay mode, `out_ref` repeats the accepted input level REF_LAT ticks after sampling. At code 0, `out_main` changes exactly one tick before `out_ref`.
- R5: The code is captured for each transition when that transition is sampled. A later change of code leaves the deadlines of transitions already queued unchanged.
- R6: Mode input high (pulse mode): a rising edge accepted at clock edge k sets `out_ref` high after edge k + REF_LAT and low after edge k + REF_LAT + code. At code 0 no pulse appears.
- R7: The pulse cannot be retriggered. Rising edges sampled at clock edges k+1 through k + REF_LAT + code are ignored. A rising edge at k + REF_LAT + code + 1 or later starts a new pulse.
- R8: In pulse mode, `out_main` carries the inverted input level, with the same delay as in R2.
- R9: In pulse mode, with `out_main` fed back to `sig_in`, the main output oscillates with a period of 2 × (REF_LAT + code) ticks.
- R10: If the input is high when reset is released, it is ignored until it has been sampled low. The first transition after that is a rising edge, and it is reproduced normally.
- R11: The queue holds DEPTH (16) pending transitions. A transition that arrives while the queue is full is dropped. It still updates the tracked input level, and it sets `ovf`, which stays high until reset.
- R12: In pulse mode, a free-running input clock gives a PWM output with the period of the input and `code` ticks high in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Signal to delay, or trigger in pulse mode |
| pulse_mode | input | 1 | 0 = delay line, 1 = one-shot with inverted main output |
| delay_code | input | CODE_W | Programmed delay in ticks |
| out_main | output | 1 | Delayed (pulse mode: inverted delayed) input |
| out_ref | output | 1 | Fixed-latency reference, or PWM pulse in pulse mode |
| ovf | output | 1 | Sticky flag: a transition was dropped because the queue was full |

## Verification
Two events can fall in the same cycle, and each has a defined outcome.

The first is the queue receiving a new transition in the very tick it releases a matured one. The stimulus places a transition exactly 2 + code ticks after an earlier one. The bench then compares every sampled tick of the main output against a model that processes each event in order.

The second is a rising trigger in the last busy tick of a pulse, or in the first free tick after it. Two separate runs place a one-tick trigger on each side of that boundary. They are judged by whether a second PWM pulse appears.

// File: rtl/tick_delay_oneshot.sv
module tick_delay_oneshot #(
  parameter int CODE_W  = 8,
  parameter int DEPTH   = 16,
  parameter int REF_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_in,
  input  logic              pulse_mode,
  input  logic [CODE_W-1:0] delay_code,
  output logic              out_main,
  output logic              out_ref,
  output logic              ovf
);

  localparam int BASE = REF_LAT - 1;
  localparam int TW   = $clog2(BASE + (1 << CODE_W) + DEPTH) + 1;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW   = $clog2(REF_LAT + (1 << CODE_W)) + 1;
  localparam logic [TW-1:0] HALF = TW'(1) << (TW - 1);

  logic               armed, cur, os_busy;
  logic [REF_LAT-1:0] ref_sh;
  logic [TW-1:0]      now;
  logic [TW:0]        q_mem [DEPTH];
  logic [AW-1:0]      wp, rp;
  logic [AW:0]        q_cnt;
  logic [OW-1:0]      os_age, os_end;

  wire              edge_ok = armed && (sig_in != cur);
  wire              q_full  = (q_cnt == (AW+1)'(DEPTH));
  wire              push    = edge_ok && !q_full;
  wire [TW:0]       head    = q_mem[rp];
  wire [TW-1:0]     lag     = now - head[TW-1:0];
  wire              pop     = (q_cnt != '0) && (lag < HALF);
  wire [TW-1:0]     due_at  = now + TW'(BASE) + TW'(delay_code);
  wire              trig    = edge_ok && sig_in && pulse_mode && !os_busy;
  wire              os_hi   = os_busy && (os_age == OW'(REF_LAT));
  wire              os_lo   = os_busy && (os_age == os_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      cur      <= 1'b0;
      ref_sh   <= '0;
      now      <= '0;
      wp       <= '0;
      rp       <= '0;
      q_cnt    <= '0;
      out_main <= 1'b0;
      out_ref  <= 1'b0;
      ovf      <= 1'b0;
      os_busy  <= 1'b0;
      os_age   <= '0;
      os_end   <= '0;
    end else begin
      now    <= now + 1'b1;
      armed  <= armed | ~sig_in;
      if (edge_ok) cur <= sig_in;
      ref_sh <= {ref_sh[REF_LAT-2:0], edge_ok ? sig_in : cur};

      if (push) begin
        q_mem[wp] <= {sig_in ^ pulse_mode, due_at};
        wp        <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (edge_ok && q_full) ovf <= 1'b1;
      if (pop) begin
        out_main <= head[TW];
        rp       <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      case ({push, pop})
        2'b10:   q_cnt <= q_cnt + 1'b1;
        2'b01:   q_cnt <= q_cnt - 1'b1;
        default: q_cnt <= q_cnt;
      endcase

      if (trig) begin
        os_busy <= 1'b1;
        os_age  <= OW'(1);
        os_end  <= OW'(REF_LAT) + OW'(delay_code);
      end else if (os_busy) begin
        os_age <= os_age + 1'b1;
        if (os_lo) os_busy <= 1'b0;
      end

      out_ref <= pulse_mode ? (os_busy && !os_lo && (out_ref || os_hi))
                            : ref_sh[REF_LAT-1];
    end
  end

endmodule

// File: rtl/tick_delay_oneshot_chk.sv
module tick_delay_oneshot_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int OW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          pulse_mode,
  input logic          out_main,
  input logic          out_ref,
  input logic          ovf,
  input logic          os_busy,
  input logic [AW:0]   q_cnt,
  input logic [OW-1:0] os_age,
  input logic [OW-1:0] os_end
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_main && !out_ref && !ovf && q_cnt == '0));

  // R2
  main_from_queue_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_main) |-> ($past(q_cnt) != '0));

  // R11
  queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_cnt <= (AW+1)'(DEPTH));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R6
  pwm_inside_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_mode) && out_ref) |-> os_busy);

  // R7
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (os_busy && os_age != os_end) |=> (os_busy && os_age == $past(os_age) + 1'b1));

endmodule

bind tick_delay_oneshot tick_delay_oneshot_chk #(.DEPTH(DEPTH), .AW(AW), .OW(OW)) chk_i (
  .clk(clk), .rst(rst), .pulse_mode(pulse_mode), .out_main(out_main),
  .out_ref(out_ref), .ovf(ovf), .os_busy(os_busy), .q_cnt(q_cnt),
  .os_age(os_age), .os_end(os_end)
);

// File: tb/tick_delay_oneshot_tb_top.sv
module tick_delay_oneshot_tb_top;

  localparam int CLK_P = 10;
  localparam int RL    = 3;
  localparam int BASE  = RL - 1;
  localparam int DEPTH = 16;
  localparam int NMAX  = 800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv = 1'b0;
  logic loop_en = 1'b0;
  logic mode = 1'b0;
  logic [7:0] code = 8'd0;
  logic out_main, out_ref, ovf;
  wire  sig_in = loop_en ? out_main : drv;

  int total = 0;
  int bad = 0;
  logic pat [NMAX];
  int   cds [NMAX];
  int   em [NMAX];
  int   er [NMAX];
  int   eo [NMAX];

  always #(CLK_P/2) clk = ~clk;

  tick_delay_oneshot #(.CODE_W(8), .DEPTH(DEPTH), .REF_LAT(RL)) dut_i (
    .clk(clk), .rst(rst), .sig_in(sig_in), .pulse_mode(mode), .delay_code(code),
    .out_main(out_main), .out_ref(out_ref), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=1 expected=0");
    finish_up();
  end

  task automatic do_reset(input logic pm, input logic lvl, input int c);
    @(negedge clk);
    rst = 1'b1; loop_en = 1'b0; mode = pm; drv = lvl; code = 8'(c);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_pat(input int n, input int c);
    for (int i = 0; i < n; i++) begin pat[i] = 1'b0; cds[i] = c; end
  endtask

  task automatic set_span(input int a, input int b, input logic v);
    for (int i = a; i < b; i++) pat[i] = v;
  endtask

  task automatic build_model(input int n, input logic pm);
    int q[$];
    logic cur;
    bit armed;
    int next_ok, ovf_at;
    cur = 1'b0; armed = 0; next_ok = 0; ovf_at = -1;
    for (int t = 0; t < n; t++) begin em[t] = 0; er[t] = 0; eo[t] = 0; end
    for (int j = 0; j < n; j++) begin
      while (q.size() > 0 && q[0] < j) void'(q.pop_front());
      if (armed && pat[j] != cur) begin
        cur = pat[j];
        if (q.size() >= DEPTH) begin
          if (ovf_at < 0) ovf_at = j + 1;
        end else begin
          q.push_back(j + BASE + cds[j]);
          for (int t = j + BASE + cds[j] + 1; t < n; t++) em[t] = pm ? int'(!cur) : int'(cur);
        end
        if (pm && cur && j >= next_ok) begin
          for (int t = j + RL + 1; t <= j + RL + cds[j] && t < n; t++) er[t] = 1;
          next_ok = j + RL + cds[j] + 1;
        end
      end
      if (pat[j] == 1'b0) armed = 1;
      if (!pm && j + RL + 1 < n) er[j + RL + 1] = int'(cur);
    end
    if (ovf_at >= 0) for (int t = ovf_at; t < n; t++) eo[t] = 1;
  endtask

  task automatic run_wave(input int n, input logic pm, input string tm, input string tr, input string to_);
    int bm, br, bo, fm, fr, fo, am, ar, ao;
    bm = 0; br = 0; bo = 0; fm = -1; fr = -1; fo = -1; am = 0; ar = 0; ao = 0;
    build_model(n, pm);
    @(negedge clk);
    rst = 1'b1; loop_en = 1'b0; mode = pm; drv = pat[0]; code = 8'(cds[0]);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < n; j++) begin
      if (int'(out_main) != em[j]) begin bm++; if (fm < 0) begin fm = j; am = int'(out_main); end end
      if (int'(out_ref) != er[j]) begin br++; if (fr < 0) begin fr = j; ar = int'(out_ref); end end
      if (int'(ovf) != eo[j]) begin bo++; if (fo < 0) begin fo = j; ao = int'(ovf); end end
      drv = pat[j];
      code = 8'(cds[j]);
      @(negedge clk);
    end
    check(bm == 0, tm, $sformatf("out_main at step %0d", fm), am, (fm < 0) ? 0 : em[fm]);
    check(br == 0, tr, $sformatf("out_ref at step %0d", fr), ar, (fr < 0) ? 0 : er[fr]);
    check(bo == 0, to_, $sformatf("ovf at step %0d", fo), ao, (fo < 0) ? 0 : eo[fo]);
  endtask

  task automatic edge_lat(input logic v, output int lm, output int lr);
    logic m0, r0;
    m0 = out_main; r0 = out_ref;
    lm = -1; lr = -1;
    drv = v;
    for (int j = 1; j < 700; j++) begin
      @(negedge clk);
      if (lm < 0 && out_main != m0) lm = j - 1;
      if (lr < 0 && out_ref != r0) lr = j - 1;
      if (lm >= 0 && lr >= 0) break;
    end
  endtask

  // R1: reset state, and queued transitions discarded by a mid-run reset
  task automatic t_reset();
    int stray;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_main == 1'b0 && out_ref == 1'b0 && ovf == 1'b0, "R1", "outputs in reset",
          int'({out_main, out_ref, ovf}), 0);
    do_reset(1'b0, 1'b0, 30);
    repeat (5) @(negedge clk);
    drv = 1'b1; repeat (4) @(negedge clk);
    drv = 1'b0; repeat (10) @(negedge clk);
    rst = 1'b1; repeat (2) @(negedge clk);
    rst = 1'b0;
    stray = 0;
    for (int j = 0; j < 80; j++) begin
      @(negedge clk);
      if (out_main || out_ref || ovf) stray++;
    end
    check(stray == 0, "R1", "outputs active after reset cleared queue", stray, 0);
  endtask

  // R2 R4: single-edge latencies
  task automatic t_latency();
    int lm, lr;
    int codes [3] = '{0, 13, 255};
    foreach (codes[i]) begin
      do_reset(1'b0, 1'b0, codes[i]);
      repeat (5) @(negedge clk);
      edge_lat(1'b1, lm, lr);
      check(lm == BASE + codes[i], "R2", $sformatf("rise latency code %0d", codes[i]), lm, BASE + codes[i]);
      check(lr == RL, "R4", $sformatf("ref latency code %0d", codes[i]), lr, RL);
      if (codes[i] == 0) check(lr - lm == 1, "R4", "main leads ref at code 0", lr - lm, 1);
    end
    do_reset(1'b0, 1'b0, 13);
    repeat (5) @(negedge clk);
    edge_lat(1'b1, lm, lr);
    repeat (30) @(negedge clk);
    edge_lat(1'b0, lm, lr);
    check(lm == BASE + 13, "R2", "fall latency code 13", lm, BASE + 13);
  endtask

  // R3: overlapping edges, one-tick pulse, push and pop in one tick
  task automatic t_overlap();
    clear_pat(160, 40);
    set_span(10, 15, 1'b1);
    set_span(22, 25, 1'b1);
    set_span(30, 31, 1'b1);
    set_span(52, 67, 1'b1);
    run_wave(160, 1'b0, "R3", "R4", "R3");
  endtask

  // R5: code change leaves queued deadline alone
  task automatic t_code_change();
    clear_pat(200, 5);
    for (int i = 8; i < 200; i++) cds[i] = 60;
    set_span(2, 12, 1'b1);
    run_wave(200, 1'b0, "R5", "R4", "R5");
  endtask

  // R6 R8: one-shot pulses and inverted main output
  task automatic t_pulse();
    clear_pat(200, 6);
    set_span(10, 14, 1'b1);
    set_span(40, 41, 1'b1);
    set_span(70, 90, 1'b1);
    run_wave(200, 1'b1, "R8", "R6", "R6");
    clear_pat(80, 0);
    set_span(10, 20, 1'b1);
    run_wave(80, 1'b1, "R8", "R6", "R6");
  endtask

  // R7: retrigger window boundary and periodic retriggers
  task automatic t_retrig();
    clear_pat(120, 20);
    set_span(10, 11, 1'b1);
    set_span(33, 34, 1'b1);
    run_wave(120, 1'b1, "R8", "R7", "R7");
    clear_pat(120, 20);
    set_span(10, 11, 1'b1);
    set_span(34, 35, 1'b1);
    run_wave(120, 1'b1, "R8", "R7", "R7");
    clear_pat(200, 20);
    for (int s = 10; s < 90; s += 8) set_span(s, s + 4, 1'b1);
    run_wave(200, 1'b1, "R8", "R7", "R7");
  endtask

  // R12: PWM from a free-running input
  task automatic t_pwm();
    int hi;
    clear_pat(320, 5);
    for (int s = 4; s < 300; s += 16) set_span(s, s + 8, 1'b1);
    run_wave(320, 1'b1, "R8", "R12", "R12");
    hi = 0;
    for (int t = 100; t < 164; t++) hi += er[t];
    check(hi == 4 * 5, "R12", "model high ticks over four periods", hi, 20);
  endtask

  // R10: input high at reset release
  task automatic t_arm();
    clear_pat(120, 3);
    set_span(0, 20, 1'b1);
    set_span(40, 120, 1'b1);
    run_wave(120, 1'b0, "R10", "R10", "R10");
  endtask

  // R11: overflow of the transition queue
  task automatic t_ovf();
    clear_pat(600, 255);
    for (int j = 5; j <= 21; j++) pat[j] = ((j - 5) % 2 == 0) ? 1'b1 : 1'b0;
    set_span(22, 600, 1'b1);
    run_wave(600, 1'b0, "R11", "R4", "R11");
  endtask

  // R9: oscillation with output looped to input
  task automatic t_loop();
    int r [3];
    int nr, w;
    logic prev;
    do_reset(1'b1, 1'b0, 7);
    repeat (3) @(negedge clk);
    drv = 1'b1; repeat (3) @(negedge clk);
    drv = 1'b0;
    w = 0;
    while (!out_main && w < 100) begin @(negedge clk); w++; end
    loop_en = 1'b1;
    prev = out_main; nr = 0;
    for (int j = 0; j < 400 && nr < 3; j++) begin
      @(negedge clk);
      if (out_main && !prev) begin r[nr] = j; nr++; end
      prev = out_main;
    end
    loop_en = 1'b0;
    check(nr == 3 && r[1] - r[0] == 2 * (RL + 7), "R9", "first loop period", (nr == 3) ? r[1] - r[0] : -1, 2 * (RL + 7));
    check(nr == 3 && r[2] - r[1] == 2 * (RL + 7), "R9", "second loop period", (nr == 3) ? r[2] - r[1] : -1, 2 * (RL + 7));
  endtask

  initial begin
    t_reset();
    t_latency();
    t_overlap();
    t_code_change();
    t_pulse();
    t_retrig();
    t_pwm();
    t_arm();
    t_ovf();
    t_loop();
    finish_up();
  end

endmodule